// File: doc/BRIEF.md
# Horizontal Raster Timing Generator

This block produces the per-line horizontal timing of a raster video controller. A free-running line counter advances once per clock. At a small set of fixed counter positions the block tests the refresh-mode input, and each passing test sets or clears one of three registered outputs: display enable, blank and horizontal sync. Each test samples the mode only during its own counter cycle. Software may therefore rewrite the mode partway through a line, and the line length and the active window then follow from whichever tests happened to pass.

Three modes are supported: a 512-cycle line, a 508-cycle line and a 224-cycle high-resolution line. A sync sequence starts 50 cycles before the end of the selected line. The sync sequence also removes display enable a fixed two clocks after sync rises, in every mode and at any counter value. If software keeps display enable alive past its normal off position, the line therefore ends at the sync point.

Top module: `hdt_timing`

## Requirements
- R1: While reset is high and on the first cycle after it, de, blank and hsync are low and the line counter is 0. With mode 00 held, de first goes high on the 57th cycle after reset is released.
- R2: The mode input is encoded as 00 = 512-cycle mode, 01 = 508-cycle mode, and 10 or 11 = 224-cycle high-resolution mode. The counter returns to 0 after value 511 in all modes, after 507 when 01 is seen at that cycle, and after 223 when bit 1 is set at that cycle.
- R3: A de-on test passes at counter 56 (mode 00), 52 (mode 01) or 4 (high-res). Each output changes one clock after the cycle in which its test passes.
- R4: A de-off test passes at 376 (mode 00), 372 (mode 01) or 164 (high-res). With the mode held, the de pulse is 320, 320 or 160 cycles wide.
- R5: Each test uses the mode value present in its own counter cycle. A write made one cycle after a test does not change that test's outcome. A write present in the test cycle does change it, so a write to high-res at counter 376 in mode 00 leaves de high until the sync removes it.
- R6: A sync test passes at counter 462 (mode 00), 458 (mode 01) or 174 (high-res), unless a sync sequence is already in progress. hsync then stays high for exactly 40 cycles, and the line period measured between hsync rises is 512, 508 or 224.
- R7: A blank test passes 4 counter positions before the sync test of the same mode. blank is high whenever hsync is high, and it stays high for 4 cycles after hsync falls.
- R8: Two clocks after hsync rises, de is forced low, in every mode and at any counter value. de never changes on the same clock that hsync rises.
- R9: Enabling de with the 508-cycle test at counter 52 and keeping it through both off tests in a 512-cycle line gives a 412-cycle de pulse, ended by the sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-timing clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Refresh-mode select, may change on any cycle |
| de | output | 1 | Display enable, registered |
| blank | output | 1 | Blanking, registered |
| hsync | output | 1 | Horizontal sync, active high, registered |

## Verification
The bench builds the block with its default parameters: line lengths 512, 508 and 224, a 40-cycle sync, 4-cycle blank margins and a 2-clock enable kill. This small configuration keeps every line short enough to sweep whole lines clock by clock, in every mode and across mode transitions. An arithmetic model of the line counter and its tests is compared with all three outputs on every cycle. Mode writes placed exactly on and one cycle after test positions produce the odd pulse widths: 316, 408 and 412 cycles.

// File: rtl/hdt_pkg.sv
package hdt_pkg;

  // Refresh-mode codes; code 2'b11 also selects high resolution.
  typedef enum logic [1:0] {
    HM_50    = 2'b00,
    HM_60    = 2'b01,
    HM_HIRES = 2'b10
  } hmode_e;

  localparam int NUM_MODES = 3;

  // Does the live mode value select test group idx (0: 512, 1: 508, 2: hires)?
  function automatic logic mode_match(input logic [1:0] m, input int idx);
    case (idx)
      0:       mode_match = (m == HM_50);
      1:       mode_match = (m == HM_60);
      default: mode_match = m[1];
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int r;
    r = (a > b) ? a : b;
    max3 = (r > c) ? r : c;
  endfunction

endpackage

// File: rtl/hdt_line_counter.sv
module hdt_line_counter #(
  parameter int MAX_LEN = 512,
  parameter int CW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap_req,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] P_LAST = CW'(MAX_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wrap_req || (cnt == P_LAST)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == '0) || (cnt == $past(cnt) + 1'b1)); // R2

endmodule

// File: rtl/hdt_mode_tests.sv
module hdt_mode_tests #(
  parameter int CW        = 9,
  parameter int LEN       = 512,
  parameter int DE_ON     = 56,
  parameter int DE_OFF    = 376,
  parameter int SYNC_POS  = 462,
  parameter int BLANK_POS = 458
) (
  input  logic [CW-1:0] cnt,
  input  logic          sel,
  output logic          wrap,
  output logic          de_on,
  output logic          de_off,
  output logic          blank_on,
  output logic          sync_on
);

  localparam logic [CW-1:0] P_END   = CW'(LEN - 1);
  localparam logic [CW-1:0] P_ON    = CW'(DE_ON);
  localparam logic [CW-1:0] P_OFF   = CW'(DE_OFF);
  localparam logic [CW-1:0] P_SYNC  = CW'(SYNC_POS);
  localparam logic [CW-1:0] P_BLANK = CW'(BLANK_POS);

  always_comb begin
    wrap     = sel && (cnt == P_END);
    de_on    = sel && (cnt == P_ON);
    de_off   = sel && (cnt == P_OFF);
    blank_on = sel && (cnt == P_BLANK);
    sync_on  = sel && (cnt == P_SYNC);
  end

endmodule

// File: rtl/hdt_sync_seq.sv
module hdt_sync_seq #(
  parameter int SYNC_LEN   = 40,
  parameter int BLANK_TAIL = 4,
  parameter int KILL_DLY   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic blank_req,
  input  logic sync_req,
  output logic hsync,
  output logic blank,
  output logic kill
);

  localparam int SEQ_LEN = SYNC_LEN + BLANK_TAIL;
  localparam int AW      = $clog2(SEQ_LEN + 1);
  localparam logic [AW-1:0] P_HS_END = AW'(SYNC_LEN - 1);
  localparam logic [AW-1:0] P_BL_END = AW'(SEQ_LEN - 1);

  logic          active;
  logic [AW-1:0] age;
  logic          sync_go;
  logic [KILL_DLY-1:0] kpipe;

  assign sync_go = sync_req && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync  <= 1'b0;
      blank  <= 1'b0;
      active <= 1'b0;
      age    <= '0;
    end else if (sync_go) begin
      hsync  <= 1'b1;
      blank  <= 1'b1;
      active <= 1'b1;
      age    <= '0;
    end else if (active) begin
      age <= age + 1'b1;
      if (age == P_HS_END) hsync <= 1'b0;
      if (age == P_BL_END) begin
        blank  <= 1'b0;
        active <= 1'b0;
      end
    end else if (blank_req) begin
      blank <= 1'b1;
    end
  end

  generate
    if (KILL_DLY == 1) begin : g_kill1
      always_ff @(posedge clk) begin
        if (rst) kpipe <= '0;
        else     kpipe <= sync_go;
      end
    end else begin : g_killn
      always_ff @(posedge clk) begin
        if (rst) kpipe <= '0;
        else     kpipe <= {kpipe[KILL_DLY-2:0], sync_go};
      end
    end
  endgenerate

  assign kill = kpipe[KILL_DLY-1];

  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    hsync |-> blank); // R7

  AST_BLANK_TAIL: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync) |-> blank); // R7

endmodule

// File: rtl/hdt_de_ctrl.sv
module hdt_de_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic de_on,
  input  logic de_off,
  input  logic kill,
  output logic de
);

  always_ff @(posedge clk) begin
    if (rst)         de <= 1'b0;
    else if (kill)   de <= 1'b0;
    else if (de_off) de <= 1'b0;
    else if (de_on)  de <= 1'b1;
  end

  AST_KILL_DROPS_DE: assert property (@(posedge clk) disable iff (rst)
    kill |=> !de); // R8

endmodule

// File: rtl/hdt_timing.sv
module hdt_timing #(
  parameter int LEN_50     = 512,
  parameter int DE_ON_50   = 56,
  parameter int DE_OFF_50  = 376,
  parameter int LEN_60     = 508,
  parameter int DE_ON_60   = 52,
  parameter int DE_OFF_60  = 372,
  parameter int LEN_HI     = 224,
  parameter int DE_ON_HI   = 4,
  parameter int DE_OFF_HI  = 164,
  parameter int SYNC_BACK  = 50,
  parameter int SYNC_LEN   = 40,
  parameter int BLANK_LEAD = 4,
  parameter int BLANK_TAIL = 4,
  parameter int KILL_DLY   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  output logic       de,
  output logic       blank,
  output logic       hsync
);

  import hdt_pkg::*;

  localparam int MAX_LEN = max3(LEN_50, LEN_60, LEN_HI);
  localparam int CW      = $clog2(MAX_LEN);

  logic [CW-1:0]        cnt;
  logic [NUM_MODES-1:0] wrap_v, on_v, off_v, blank_v, sync_v;
  logic                 kill;

  hdt_line_counter #(.MAX_LEN(MAX_LEN), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .wrap_req (|wrap_v),
    .cnt      (cnt)
  );

  generate
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
      localparam int LEN = (g == 0) ? LEN_50    : (g == 1) ? LEN_60    : LEN_HI;
      localparam int ON  = (g == 0) ? DE_ON_50  : (g == 1) ? DE_ON_60  : DE_ON_HI;
      localparam int OFF = (g == 0) ? DE_OFF_50 : (g == 1) ? DE_OFF_60 : DE_OFF_HI;
      hdt_mode_tests #(
        .CW        (CW),
        .LEN       (LEN),
        .DE_ON     (ON),
        .DE_OFF    (OFF),
        .SYNC_POS  (LEN - SYNC_BACK),
        .BLANK_POS (LEN - SYNC_BACK - BLANK_LEAD)
      ) u_tests (
        .cnt      (cnt),
        .sel      (mode_match(mode, g)),
        .wrap     (wrap_v[g]),
        .de_on    (on_v[g]),
        .de_off   (off_v[g]),
        .blank_on (blank_v[g]),
        .sync_on  (sync_v[g])
      );
    end
  endgenerate

  hdt_sync_seq #(
    .SYNC_LEN   (SYNC_LEN),
    .BLANK_TAIL (BLANK_TAIL),
    .KILL_DLY   (KILL_DLY)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .blank_req (|blank_v),
    .sync_req  (|sync_v),
    .hsync     (hsync),
    .blank     (blank),
    .kill      (kill)
  );

  hdt_de_ctrl u_de (
    .clk    (clk),
    .rst    (rst),
    .de_on  (|on_v),
    .de_off (|off_v),
    .kill   (kill),
    .de     (de)
  );

  AST_DE_STILL_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> $stable(de)); // R8

  AST_DE_RISE_POS: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> (cnt == CW'(DE_ON_50 + 1)) || (cnt == CW'(DE_ON_60 + 1))
                  || (cnt == CW'(DE_ON_HI + 1))); // R3

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) ##1 (cnt == '0) |-> ($past(cnt) == CW'(MAX_LEN - 1))
      || ($past(cnt) == CW'(LEN_60 - 1)) || ($past(cnt) == CW'(LEN_HI - 1))); // R2

endmodule

// File: tb/hdt_timing_test.sv
module hdt_timing_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       de, blank, hsync;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  hdt_timing uut (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .de    (de),
    .blank (blank),
    .hsync (hsync)
  );

  // ---------------- arithmetic reference model ----------------
  int m_cnt, m_age;
  bit m_de, m_bl, m_hs, m_act, m_k1, m_k2;
  int t_len, t_on, t_off, t_sp;
  bit t_go;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_de <= 0; m_bl <= 0; m_hs <= 0;
      m_act <= 0; m_age <= 0; m_k1 <= 0; m_k2 <= 0;
    end else begin
      case (mode)
        2'b00:   begin t_len = 512; t_on = 56; t_off = 376; end
        2'b01:   begin t_len = 508; t_on = 52; t_off = 372; end
        default: begin t_len = 224; t_on = 4;  t_off = 164; end
      endcase
      t_sp = t_len - 50;
      t_go = (m_cnt == t_sp) && !m_act;
      m_cnt <= (m_cnt == 511 || m_cnt == t_len - 1) ? 0 : m_cnt + 1;
      m_k1 <= t_go;
      m_k2 <= m_k1;
      if (m_k2)                m_de <= 0;
      else if (m_cnt == t_off) m_de <= 0;
      else if (m_cnt == t_on)  m_de <= 1;
      if (t_go) begin
        m_hs <= 1; m_bl <= 1; m_act <= 1; m_age <= 0;
      end else if (m_act) begin
        m_age <= m_age + 1;
        if (m_age == 39) m_hs <= 0;
        if (m_age == 43) begin m_bl <= 0; m_act <= 0; end
      end else if (m_cnt == t_sp - 4) begin
        m_bl <= 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- measurements and per-cycle comparison ----------------
  bit p_de, p_hs, p_bl;
  int de_run, hs_run, bl_run, tail_run, since_hs, per_run, hs_rises;
  int last_de_w, last_hs_w, last_lead, last_tail, last_gap, last_per;

  always @(negedge clk) begin
    if (rst) begin
      if (!done) begin
        chk("R1 de in reset", de, 0);
        chk("R1 hsync in reset", hsync, 0);
        chk("R1 blank in reset", blank, 0);
      end
      p_de = 0; p_hs = 0; p_bl = 0;
      de_run = 0; hs_run = 0; bl_run = 0; tail_run = 0;
      since_hs = 1000; per_run = 0; hs_rises = 0;
    end else if (!done) begin
      chk("R3 R4 de per-cycle", de, m_de);
      chk("R6 hsync per-cycle", hsync, m_hs);
      chk("R7 blank per-cycle", blank, m_bl);
      per_run++;
      since_hs++;
      if (de) de_run++;
      if (hsync) hs_run++;
      if (blank) bl_run++;
      if (blank && !hsync) tail_run++;
      if (hsync && !p_hs) begin
        last_lead = bl_run - 1;
        last_per  = per_run;
        per_run   = 0;
        since_hs  = 0;
        tail_run  = 0;
        hs_rises++;
      end
      if (!de && p_de) begin last_de_w = de_run; last_gap = since_hs; de_run = 0; end
      if (!hsync && p_hs) begin last_hs_w = hs_run; hs_run = 0; end
      if (!blank && p_bl) begin last_tail = tail_run; bl_run = 0; end
      p_de = de; p_hs = hsync; p_bl = blank;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (m_cnt != v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int first_de;
    int rises0;
    cycles(4);
    rst = 1'b0;
    // R1: first cycle after reset, and first de rise position
    first_de = 0;
    for (int i = 1; i < 600; i++) begin
      @(negedge clk); #1;
      if (i == 1) begin
        chk("R1 de after reset", de, 0);
        chk("R1 hsync after reset", hsync, 0);
        chk("R1 blank after reset", blank, 0);
      end
      if (de && first_de == 0) first_de = i;
    end
    chk("R1 R3 first de rise cycle", first_de, 57);

    // 512-cycle mode, held
    cycles(3 * 512); #1;
    chk("R4 de width mode 00", last_de_w, 320);
    chk("R6 hsync width mode 00", last_hs_w, 40);
    chk("R6 line period mode 00", last_per, 512);
    chk("R7 blank lead mode 00", last_lead, 4);
    chk("R7 blank tail mode 00", last_tail, 4);

    // 508-cycle mode
    mode = 2'b01;
    cycles(3 * 512); #1;
    chk("R4 de width mode 01", last_de_w, 320);
    chk("R2 R6 line period mode 01", last_per, 508);
    chk("R7 blank lead mode 01", last_lead, 4);

    // high-resolution modes (10 and 11)
    mode = 2'b10;
    cycles(4 * 224); #1;
    chk("R4 de width hires", last_de_w, 160);
    chk("R2 R6 line period hires", last_per, 224);
    chk("R6 hsync width hires", last_hs_w, 40);
    mode = 2'b11;
    cycles(4 * 224); #1;
    chk("R2 line period code 11", last_per, 224);
    chk("R7 blank tail hires", last_tail, 4);

    // back to 512-cycle mode
    mode = 2'b00;
    cycles(2 * 512);

    // R5: write one cycle after the on test has no effect; 508 off test ends it
    wait_cnt(57); mode = 2'b01;
    wait_cnt(380); #1;
    chk("R5 late write keeps de, width", last_de_w, 316);
    mode = 2'b00;
    cycles(512);

    // R5 R8: write present at the off test cancels it; sync kills de
    wait_cnt(376); mode = 2'b10;
    wait_cnt(377); mode = 2'b00;
    wait_cnt(470); #1;
    chk("R5 write at test position, width", last_de_w, 408);
    chk("R8 de drop after hsync rise", last_gap, 2);
    cycles(512);

    // R9: widest line, on via 508 test at 52, both off tests dodged
    wait_cnt(51); mode = 2'b01;
    wait_cnt(53); mode = 2'b00;
    wait_cnt(370); mode = 2'b10;
    wait_cnt(377); mode = 2'b00;
    wait_cnt(470); #1;
    chk("R9 widest de width", last_de_w, 412);
    chk("R8 forced drop delay", last_gap, 2);
    cycles(512);

    // R6: second sync test inside a running sequence is ignored
    wait_cnt(440); #1;
    rises0 = hs_rises;
    wait_cnt(457); mode = 2'b01;
    wait_cnt(459); mode = 2'b00;
    wait_cnt(510); #1;
    chk("R6 single hsync rise", hs_rises - rises0, 1);
    chk("R6 hsync width with ignored test", last_hs_w, 40);

    // R8: kill in 508-cycle mode with de kept on past 372
    mode = 2'b01;
    cycles(2 * 512);
    wait_cnt(370); mode = 2'b10;
    wait_cnt(373); mode = 2'b01;
    wait_cnt(480); #1;
    chk("R8 kill in mode 01 width", last_de_w, 408);
    chk("R8 kill delay in mode 01", last_gap, 2);

    cycles(600);
    finish_run();
  end

endmodule